// File: doc/BRIEF.md
# Spare-Area Buffer Address Mapper

This block turns one linear request into the spare (out-of-band) region of a NAND page into a short list of accesses to the controller's per-chunk spare buffers. A request is a start offset and a byte count. Each page is split into 512-byte chunks, and each chunk owns one spare buffer. Only an even number of bytes in each buffer is in use, and any bytes left over belong to the final buffer. The mapper takes the page size, the spare size, the offset and the count with a start strobe. It then emits one segment per handshake. Each segment is a buffer-space address and a burst length, and a done pulse follows the last segment.

A single iterative divide locates the first buffer and the position inside it. Every later segment starts at offset zero of the next buffer, so no further division is needed. A start is taken only while `req_ready` is high. Page sizes outside the supported set, and geometries that leave zero usable bytes per buffer, are rejected with an error flag.

Top module: `spare_map`

## Requirements
- R1: After reset, req_ready is 1 and seg_valid, done and cfg_err are 0.
- R2: The chunk count is 1, 4 or 8 for page sizes 512, 2048 or 4096. The used size per buffer is the spare size divided by the chunk count, then rounded down to an even number.
- R3: The first buffer index is start offset / used size, limited to at most 7. The in-buffer offset is start offset minus index × used size.
- R4: seg_addr equals 0x1000 + index × 64 + in-buffer offset.
- R5: For an index below 7, seg_len is the smaller of (used size − in-buffer offset) and the bytes still outstanding. For index 7, seg_len is all the outstanding bytes.
- R6: Each segment after the first uses the next buffer index with in-buffer offset 0. done is high for exactly one cycle, in the cycle after the final segment handshake.
- R7: While seg_valid is 1 and seg_ready is 0, seg_valid, seg_addr and seg_len hold their values. The mapper advances only on a handshake.
- R8: req_ready is 1 only when no request is in progress, and is never 1 together with seg_valid. A start while req_ready is 0 has no effect.
- R9: A start with a page size other than 512, 2048 or 4096, or with a used size of 0, sets cfg_err and produces neither a segment nor done. cfg_err clears at the next accepted start.
- R10: A valid start with a byte count of 0 gives done in the next cycle and no segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken while req_ready is 1 |
| req_ready | output | 1 | Idle, able to take a request |
| page_bytes | input | PAGE_W | Page size in bytes |
| spare_bytes | input | SPARE_W | Spare size in bytes |
| start_offs | input | OFFS_W | Start offset into the spare region |
| byte_count | input | CNT_W | Bytes requested |
| seg_valid | output | 1 | Segment present |
| seg_ready | input | 1 | Consumer takes the segment |
| seg_addr | output | ADDR_W | Buffer-space address of the segment |
| seg_len | output | CNT_W | Segment length in bytes |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Last start was rejected for its geometry |

## Verification
The mapper is exercised with several geometries:
- An evenly divisible 2048/64 layout checks the plain four-way split.
- A 2048/70 layout, where 17 rounds down to 16, exposes any missing even rounding.
- A 4096/218 request runs across buffer 6 into the leftover tail of buffer 7.
- An offset past 8 × used size checks the clamp to index 7.
- A small 512-page request checks a segment that begins mid-buffer.

Further runs cover the other paths. A stalled consumer checks that the segment holds. A start during a transfer must be ignored, which shows in unchanged segments. A zero count must complete with no segment. Illegal page sizes and zero used sizes must raise cfg_err with no output.

// File: rtl/spare_map_pkg.sv
package spare_map_pkg;
   typedef enum logic [1:0] {
      MAP_IDLE = 2'd0,
      MAP_DIV  = 2'd1,
      MAP_EMIT = 2'd2
   } map_state_e;

   localparam int unsigned CHUNK_BYTES = 512;
endpackage

// File: rtl/spm_geom.sv
module spm_geom
   import spare_map_pkg::*;
#(
   parameter int PAGE_W  = 13,
   parameter int SPARE_W = 8
) (
   input  logic [PAGE_W-1:0]  page_bytes,
   input  logic [SPARE_W-1:0] spare_bytes,
   output logic [SPARE_W-1:0] used_bytes,
   output logic               cfg_bad
);
   localparam logic [PAGE_W-1:0] PG_ONE   = PAGE_W'(CHUNK_BYTES);
   localparam logic [PAGE_W-1:0] PG_FOUR  = PAGE_W'(CHUNK_BYTES * 4);
   localparam logic [PAGE_W-1:0] PG_EIGHT = PAGE_W'(CHUNK_BYTES * 8);

   logic [1:0]         shift_amt;
   logic               page_ok;
   logic [SPARE_W-1:0] per_chunk;

   always_comb begin
      page_ok   = 1'b1;
      shift_amt = 2'd0;
      case (page_bytes)
         PG_ONE:   shift_amt = 2'd0;
         PG_FOUR:  shift_amt = 2'd2;
         PG_EIGHT: shift_amt = 2'd3;
         default:  page_ok   = 1'b0;
      endcase
      per_chunk  = spare_bytes >> shift_amt;
      used_bytes = {per_chunk[SPARE_W-1:1], 1'b0};
      cfg_bad    = !page_ok || (used_bytes == '0);
   end
endmodule

// File: rtl/spm_div.sv
module spm_div #(
   parameter int DVD_W = 8,
   parameter int DVS_W = 8,
   parameter int STEPS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [DVD_W-1:0] dividend,
   input  logic [DVS_W-1:0] divisor,
   output logic             fin,
   output logic [DVD_W-1:0] quotient,
   output logic [DVS_W-1:0] remainder
);
   localparam int ITER  = DVD_W / STEPS;
   localparam int ITR_W = $clog2(ITER + 1);

   if (DVD_W % STEPS != 0) begin : g_bad_steps
      $error("spm_div: DVD_W must be a multiple of STEPS");
   end

   logic [DVS_W-1:0] part_r;
   logic [DVD_W-1:0] quo_r;
   logic [DVS_W-1:0] dvs_r;
   logic [ITR_W-1:0] cnt_r;
   logic             busy_r;
   logic             fin_r;

   logic [STEPS:0][DVS_W-1:0] pr;
   logic [STEPS:0][DVD_W-1:0] qq;

   assign pr[0] = part_r;
   assign qq[0] = quo_r;

   for (genvar g = 0; g < STEPS; g++) begin : g_stage
      logic [DVS_W:0] trial;
      logic [DVS_W:0] diff;
      logic           ge;
      assign trial     = {pr[g], qq[g][DVD_W-1]};
      assign diff      = trial - {1'b0, dvs_r};
      assign ge        = trial >= {1'b0, dvs_r};
      assign pr[g+1]   = ge ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
      assign qq[g+1]   = {qq[g][DVD_W-2:0], ge};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_r <= '0;
         quo_r  <= '0;
         dvs_r  <= '0;
         cnt_r  <= '0;
         busy_r <= 1'b0;
         fin_r  <= 1'b0;
      end else begin
         fin_r <= 1'b0;
         if (go) begin
            part_r <= '0;
            quo_r  <= dividend;
            dvs_r  <= divisor;
            cnt_r  <= ITR_W'(ITER);
            busy_r <= 1'b1;
         end else if (busy_r) begin
            part_r <= pr[STEPS];
            quo_r  <= qq[STEPS];
            cnt_r  <= cnt_r - 1'b1;
            if (cnt_r == ITR_W'(1)) begin
               busy_r <= 1'b0;
               fin_r  <= 1'b1;
            end
         end
      end
   end

   assign fin       = fin_r;
   assign quotient  = quo_r;
   assign remainder = part_r;
endmodule

// File: rtl/spm_seg.sv
module spm_seg #(
   parameter int ADDR_W     = 16,
   parameter int IDX_W      = 3,
   parameter int OFFS_W     = 8,
   parameter int SPARE_W    = 8,
   parameter int CNT_W      = 9,
   parameter int SPARE_BASE = 32'h1000,
   parameter int BUF_SPAN   = 64
) (
   input  logic [IDX_W-1:0]   buf_idx,
   input  logic [OFFS_W-1:0]  inb,
   input  logic [SPARE_W-1:0] used,
   input  logic [CNT_W-1:0]   rem,
   output logic [ADDR_W-1:0]  addr,
   output logic [CNT_W-1:0]   len
);
   localparam logic [IDX_W-1:0] LAST_IDX = '1;

   logic [CNT_W-1:0] room;

   always_comb begin
      room = CNT_W'(used) - CNT_W'(inb);
      if (buf_idx == LAST_IDX)
         len = rem;
      else
         len = (room < rem) ? room : rem;
      addr = ADDR_W'(SPARE_BASE) + ADDR_W'(buf_idx) * ADDR_W'(BUF_SPAN)
           + ADDR_W'(inb);
   end
endmodule

// File: rtl/spare_map.sv
module spare_map
   import spare_map_pkg::*;
#(
   parameter int PAGE_W     = 13,
   parameter int SPARE_W    = 8,
   parameter int OFFS_W     = 8,
   parameter int CNT_W      = 9,
   parameter int ADDR_W     = 16,
   parameter int BUF_COUNT  = 8,
   parameter int BUF_SPAN   = 64,
   parameter int SPARE_BASE = 32'h1000,
   parameter int DIV_STEPS  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic               req_ready,
   input  logic [PAGE_W-1:0]  page_bytes,
   input  logic [SPARE_W-1:0] spare_bytes,
   input  logic [OFFS_W-1:0]  start_offs,
   input  logic [CNT_W-1:0]   byte_count,
   output logic               seg_valid,
   input  logic               seg_ready,
   output logic [ADDR_W-1:0]  seg_addr,
   output logic [CNT_W-1:0]   seg_len,
   output logic               done,
   output logic               cfg_err
);
   localparam int IDX_W    = $clog2(BUF_COUNT);
   localparam int LAST_IDX = BUF_COUNT - 1;
   localparam int WW       = OFFS_W + SPARE_W;

   if (BUF_COUNT != (1 << IDX_W) || BUF_COUNT < 8) begin : g_bad_bufs
      $error("spare_map: BUF_COUNT must be a power of two, at least 8");
   end
   if (PAGE_W < 13) begin : g_bad_page
      $error("spare_map: PAGE_W too narrow for 4096-byte pages");
   end
   if (CNT_W <= SPARE_W || CNT_W <= OFFS_W) begin : g_bad_cnt
      $error("spare_map: CNT_W must exceed SPARE_W and OFFS_W");
   end
   if (OFFS_W < IDX_W) begin : g_bad_offs
      $error("spare_map: OFFS_W narrower than buffer index");
   end

   map_state_e         state_r;
   logic [OFFS_W-1:0]  offs_r;
   logic [CNT_W-1:0]   rem_r;
   logic [SPARE_W-1:0] used_r;
   logic [IDX_W-1:0]   buf_r;
   logic [OFFS_W-1:0]  inb_r;
   logic               done_r;
   logic               err_r;

   logic [SPARE_W-1:0] geo_used;
   logic               geo_bad;
   logic               div_go;
   logic               div_fin;
   logic [OFFS_W-1:0]  div_q;
   logic [SPARE_W-1:0] div_r;
   logic               clamp;
   logic [WW-1:0]      clamp_off;

   spm_geom #(.PAGE_W(PAGE_W), .SPARE_W(SPARE_W)) u_geom (
      .page_bytes (page_bytes),
      .spare_bytes(spare_bytes),
      .used_bytes (geo_used),
      .cfg_bad    (geo_bad)
   );

   assign div_go = (state_r == MAP_IDLE) && start && !geo_bad
                && (byte_count != '0);

   spm_div #(.DVD_W(OFFS_W), .DVS_W(SPARE_W), .STEPS(DIV_STEPS)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (div_go),
      .dividend (start_offs),
      .divisor  (geo_used),
      .fin      (div_fin),
      .quotient (div_q),
      .remainder(div_r)
   );

   assign clamp     = div_q > OFFS_W'(LAST_IDX);
   assign clamp_off = WW'(offs_r) - WW'(LAST_IDX) * WW'(used_r);

   spm_seg #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFFS_W(OFFS_W), .SPARE_W(SPARE_W),
      .CNT_W(CNT_W), .SPARE_BASE(SPARE_BASE), .BUF_SPAN(BUF_SPAN)
   ) u_seg (
      .buf_idx(buf_r),
      .inb    (inb_r),
      .used   (used_r),
      .rem    (rem_r),
      .addr   (seg_addr),
      .len    (seg_len)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_r <= MAP_IDLE;
         offs_r  <= '0;
         rem_r   <= '0;
         used_r  <= '0;
         buf_r   <= '0;
         inb_r   <= '0;
         done_r  <= 1'b0;
         err_r   <= 1'b0;
      end else begin
         done_r <= 1'b0;
         case (state_r)
            MAP_IDLE: begin
               if (start) begin
                  if (geo_bad) begin
                     err_r <= 1'b1;
                  end else begin
                     err_r <= 1'b0;
                     if (byte_count == '0) begin
                        done_r <= 1'b1;
                     end else begin
                        offs_r  <= start_offs;
                        rem_r   <= byte_count;
                        used_r  <= geo_used;
                        state_r <= MAP_DIV;
                     end
                  end
               end
            end
            MAP_DIV: begin
               if (div_fin) begin
                  if (clamp) begin
                     buf_r <= IDX_W'(LAST_IDX);
                     inb_r <= clamp_off[OFFS_W-1:0];
                  end else begin
                     buf_r <= div_q[IDX_W-1:0];
                     inb_r <= OFFS_W'(div_r);
                  end
                  state_r <= MAP_EMIT;
               end
            end
            MAP_EMIT: begin
               if (seg_ready) begin
                  if (rem_r == seg_len) begin
                     done_r  <= 1'b1;
                     state_r <= MAP_IDLE;
                  end else begin
                     rem_r <= rem_r - seg_len;
                     buf_r <= buf_r + 1'b1;
                     inb_r <= '0;
                  end
               end
            end
            default: state_r <= MAP_IDLE;
         endcase
      end
   end

   assign req_ready = (state_r == MAP_IDLE);
   assign seg_valid = (state_r == MAP_EMIT);
   assign done      = done_r;
   assign cfg_err   = err_r;
endmodule

// File: rtl/spare_map_chk.sv
module spare_map_chk #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              seg_valid,
   input logic              seg_ready,
   input logic [ADDR_W-1:0] seg_addr,
   input logic [CNT_W-1:0]  seg_len,
   input logic              done,
   input logic              cfg_err
);
   a_r8_ready_vs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> !req_ready);

   a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr)
                                     && $stable(seg_len)));

   a_r5_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> (seg_len != '0));

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!seg_valid && !done));
endmodule

bind spare_map spare_map_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_ready(req_ready),
   .seg_valid(seg_valid),
   .seg_ready(seg_ready),
   .seg_addr (seg_addr),
   .seg_len  (seg_len),
   .done     (done),
   .cfg_err  (cfg_err)
);

// File: tb/spare_map_test.sv
module spare_map_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        req_ready;
   logic [12:0] page_bytes = '0;
   logic [7:0]  spare_bytes = '0;
   logic [7:0]  start_offs = '0;
   logic [8:0]  byte_count = '0;
   logic        seg_valid;
   logic        seg_ready = 1'b0;
   logic [15:0] seg_addr;
   logic [8:0]  seg_len;
   logic        done;
   logic        cfg_err;

   int nchk = 0;
   int nerr = 0;
   int exp_n;
   int exp_addr [0:15];
   int exp_len  [0:15];

   always #(CLK_PERIOD/2) clk = ~clk;

   spare_map uut (
      .clk(clk), .rst_n(rst_n), .start(start), .req_ready(req_ready),
      .page_bytes(page_bytes), .spare_bytes(spare_bytes),
      .start_offs(start_offs), .byte_count(byte_count),
      .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
      .seg_len(seg_len), .done(done), .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Expected segment list built from R2..R6; exp_n = -1 means rejected (R9).
   task automatic build_exp(input int page, spare, off, cnt);
      int chunks, sb, s, o, rem, len;
      exp_n = 0;
      case (page)
         512: chunks = 1;
         2048: chunks = 4;
         4096: chunks = 8;
         default: chunks = 0;
      endcase
      if (chunks == 0) begin exp_n = -1; return; end
      sb = ((spare / chunks) / 2) * 2;
      if (sb == 0) begin exp_n = -1; return; end
      s = off / sb;
      if (s > 7) s = 7;
      o = off - s * sb;
      rem = cnt;
      while (rem > 0) begin
         if (s == 7) len = rem;
         else len = (sb - o < rem) ? sb - o : rem;
         exp_addr[exp_n] = 'h1000 + s * 64 + o;
         exp_len[exp_n]  = len;
         exp_n++;
         rem -= len;
         s++;
         o = 0;
      end
   endtask

   task automatic xfer(input string req, input int page, spare, off, cnt,
                       input int stall, input bit poke);
      int  idx = 0;
      int  waited = 0;
      bit  seen_done = 0;
      bit  poked = 0;
      build_exp(page, spare, off, cnt);
      @(negedge clk);
      check(req_ready == 1'b1, "R8 idle before start", int'(req_ready), 1);
      page_bytes  = 13'(page);
      spare_bytes = 8'(spare);
      start_offs  = 8'(off);
      byte_count  = 9'(cnt);
      start       = 1'b1;
      for (int cyc = 0; cyc < 400 && !seen_done; cyc++) begin
         @(negedge clk);
         start = 1'b0;
         if (poke && !poked && !req_ready && !done) begin
            check(req_ready == 1'b0, "R8 busy", int'(req_ready), 0);
            start_offs = 8'd0;
            byte_count = 9'd1;
            start      = 1'b1;
            poked      = 1'b1;
         end
         if (done) begin
            seen_done = 1'b1;
            seg_ready = 1'b0;
         end else if (seg_valid) begin
            if (idx < exp_n) begin
               check(seg_addr == 16'(exp_addr[idx]), {req, " R4 addr"},
                     int'(seg_addr), exp_addr[idx]);
               check(seg_len == 9'(exp_len[idx]), {req, " R5 len"},
                     int'(seg_len), exp_len[idx]);
            end else begin
               check(1'b0, {req, " R6 extra segment"}, idx + 1, exp_n);
            end
            if (waited < stall) begin
               seg_ready = 1'b0;
               waited++;
            end else begin
               seg_ready = 1'b1;
               idx++;
               waited = 0;
            end
         end else begin
            seg_ready = 1'b0;
         end
      end
      check(seen_done, {req, " R6 done seen"}, int'(seen_done), 1);
      check(idx == exp_n, {req, " R6 segment count"}, idx, exp_n);
      check(cfg_err == 1'b0, {req, " R9 err clear"}, int'(cfg_err), 0);
      @(negedge clk);
      check(done == 1'b0, {req, " R6 done one cycle"}, int'(done), 0);
   endtask

   task automatic bad_cfg(input string req, input int page, spare);
      @(negedge clk);
      page_bytes  = 13'(page);
      spare_bytes = 8'(spare);
      start_offs  = 8'd0;
      byte_count  = 9'd4;
      start       = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(cfg_err == 1'b1, {req, " R9 err set"}, int'(cfg_err), 1);
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         check(!seg_valid && !done && req_ready, {req, " R9 quiet"},
               int'({seg_valid, done, req_ready}), 1);
      end
   endtask

   task automatic reset_state;
      @(negedge clk);
      check(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
      check(seg_valid == 1'b0, "R1 seg_valid", int'(seg_valid), 0);
      check(done == 1'b0, "R1 done", int'(done), 0);
      check(cfg_err == 1'b0, "R1 cfg_err", int'(cfg_err), 0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      reset_state();
      // R2: even split 2048/64 -> 16 per buffer, four segments
      xfer("R2 even split", 2048, 64, 0, 64, 0, 1'b0);
      // R2: 70/4 = 17 rounds to 16
      xfer("R2 even rounding", 2048, 70, 16, 4, 0, 1'b0);
      // R3: mid-buffer start on a 512 page
      xfer("R3 mid buffer", 512, 16, 5, 3, 0, 1'b0);
      // R5: into the tail of buffer 7
      xfer("R5 tail spill", 4096, 218, 180, 38, 0, 1'b0);
      // R3: index clamped to 7
      xfer("R3 clamp", 4096, 218, 210, 8, 0, 1'b0);
      // R7: consumer stalls two cycles per segment
      xfer("R7 stall", 2048, 64, 8, 40, 2, 1'b0);
      // R8: start pulsed while busy is ignored
      xfer("R8 busy start", 4096, 128, 20, 30, 0, 1'b1);
      // R10: zero count
      xfer("R10 zero count", 2048, 64, 3, 0, 0, 1'b0);
      // R9: illegal page and zero used size
      bad_cfg("R9 page 1024", 1024, 64);
      bad_cfg("R9 used zero", 4096, 8);
      xfer("R9 recover", 4096, 218, 0, 30, 0, 1'b0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule